// File: doc/BRIEF.md
# BCD Time-of-Day Alarm with Repeat Masks

This block watches a running BCD calendar (seconds, minutes, hours and day of month) that is supplied from outside, and raises a one-cycle interrupt pulse when the calendar reaches a programmed alarm time. Four alarm bytes hold the target time in BCD. Bit 7 of each byte is a mask bit. The pattern of the four mask bits selects how often the alarm repeats: once a month, once a day, once an hour, once a minute, or every second.

Software reaches the alarm bytes and a one-bit alarm enable through a byte-wide register port. Reads are combinational. Writes take effect on the clock edge. A write to an alarm byte whose BCD value is out of range is dropped, and the byte keeps its old contents. Matches are evaluated only on a one-second tick input, so each qualifying second gives exactly one pulse.

Top module: `tod_alarm`

## Requirements
- R1: After reset, the four alarm bytes read 0x00, the enable bit is 0, and `irq` is low.
- R2: Register offsets are 0 seconds, 1 minutes, 2 hours, 3 day of month, and 4 control (bit 0 is the alarm enable). A read of offsets 0 to 3 returns the stored byte unchanged, mask bit included. Offset 4 reads as {7'b0, enable}. Offsets 5 to 7 read 0x00 and ignore writes.
- R3: A write to seconds or minutes is stored in full only if bits 6:4 times ten plus bits 3:0 is at most 59. Otherwise the byte is unchanged.
- R4: A write to hours is stored in full only if bits 5:4 times ten plus bits 3:0 is at most 23. Otherwise the byte is unchanged.
- R5: A write to day of month is stored in full only if bits 4:0 are nonzero. Otherwise the byte is unchanged.
- R6: With all four mask bits clear, a tick fires the alarm only when day (bits 4:0), hour (bits 5:0), minute (bits 6:0) and second (bits 6:0) all equal the calendar.
- R7: With only the day mask set, a tick fires when hour, minute and second match, whatever the day.
- R8: With the day and hour masks set and the other two clear, a tick fires when minute and second match.
- R9: With the day, hour and minute masks set and the seconds mask clear, a tick fires when the second matches.
- R10: Any other mask pattern fires on every tick.
- R11: `irq` is high for exactly the one cycle after a firing tick, and only when the enable bit is 1. Without a tick, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for `addr` (combinational) |
| tick | input | 1 | One-cycle pulse at each calendar second |
| cal_sec | input | 8 | Calendar seconds, BCD |
| cal_min | input | 8 | Calendar minutes, BCD |
| cal_hour | input | 8 | Calendar hours, BCD |
| cal_date | input | 8 | Calendar day of month, BCD |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
The assertions assume three things about the inputs:
- `tick` is a single-cycle pulse.
- The calendar fields are stable around each tick.
- Register writes and ticks are separate events.

Under these assumptions, a pulse on `irq` is traced back to the tick in the cycle before it. The stimulus drives every input on the falling edge. It raises `tick` for one cycle at a time, with the calendar values already set. It performs no register write in a tick cycle and spaces ticks at least two cycles apart.

// File: rtl/tod_alarm.sv
module tod_alarm #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              tick,
  input  logic [7:0]        cal_sec,
  input  logic [7:0]        cal_min,
  input  logic [7:0]        cal_hour,
  input  logic [7:0]        cal_date,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4);

  logic [7:0] al_sec, al_min, al_hour, al_date;
  logic       al_en;

  logic [6:0] val_ms;
  logic [5:0] val_hr;
  logic       ok_ms, ok_hr, ok_dt;

  assign val_ms = {4'b0, wr_data[6:4]} * 7'd10 + {3'b0, wr_data[3:0]};
  assign val_hr = {4'b0, wr_data[5:4]} * 6'd10 + {2'b0, wr_data[3:0]};
  assign ok_ms  = val_ms <= 7'd59;
  assign ok_hr  = val_hr <= 6'd23;
  assign ok_dt  = wr_data[4:0] != 5'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_sec  <= 8'h00;
      al_min  <= 8'h00;
      al_hour <= 8'h00;
      al_date <= 8'h00;
      al_en   <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_SEC:   if (ok_ms) al_sec  <= wr_data;
        A_MIN:   if (ok_ms) al_min  <= wr_data;
        A_HOUR:  if (ok_hr) al_hour <= wr_data;
        A_DATE:  if (ok_dt) al_date <= wr_data;
        A_CTRL:  al_en <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_SEC:   rd_data = al_sec;
      A_MIN:   rd_data = al_min;
      A_HOUR:  rd_data = al_hour;
      A_DATE:  rd_data = al_date;
      A_CTRL:  rd_data = {7'b0, al_en};
      default: rd_data = 8'h00;
    endcase
  end

  logic eq_s, eq_m, eq_h, eq_d;
  assign eq_s = al_sec[6:0]  == cal_sec[6:0];
  assign eq_m = al_min[6:0]  == cal_min[6:0];
  assign eq_h = al_hour[5:0] == cal_hour[5:0];
  assign eq_d = al_date[4:0] == cal_date[4:0];

  logic [3:0] masks;
  logic       hit;
  assign masks = {al_date[7], al_hour[7], al_min[7], al_sec[7]};

  always_comb begin
    case (masks)
      4'b0000: hit = eq_d & eq_h & eq_m & eq_s;
      4'b1000: hit = eq_h & eq_m & eq_s;
      4'b1100: hit = eq_m & eq_s;
      4'b1110: hit = eq_s;
      default: hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= tick & al_en & hit;
  end
endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wr_data,
  input logic       tick,
  input logic       irq,
  input logic [7:0] al_sec,
  input logic [7:0] al_hour,
  input logic [7:0] al_date,
  input logic       al_en
);
  logic sec_bad, hr_bad;
  assign sec_bad = (wr_data[6:4] > 3'd5) || (wr_data[3:0] > 4'd9 && wr_data[6:4] == 3'd5);
  assign hr_bad  = (wr_data[5:4] == 2'd2 && wr_data[3:0] > 4'd3) || (wr_data[5:4] == 2'd3)
                   || (wr_data[5:4] == 2'd1 && wr_data[3:0] > 4'd13);

  assert_irq_needs_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick) && $past(al_en));

  assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> !irq);

  assert_sec_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && sec_bad) |=> $stable(al_sec));

  assert_sec_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && !sec_bad) |=> al_sec == $past(wr_data));

  assert_hour_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2 && hr_bad) |=> $stable(al_hour));

  assert_date_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3 && wr_data[4:0] == 5'd0) |=> $stable(al_date));
endmodule

bind tod_alarm tod_alarm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .tick(tick), .irq(irq), .al_sec(al_sec), .al_hour(al_hour),
  .al_date(al_date), .al_en(al_en)
);

// File: tb/tod_alarm_bench.sv
module tod_alarm_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick = 1'b0;
  logic [7:0] cal_sec = 8'h00, cal_min = 8'h00, cal_hour = 8'h00, cal_date = 8'h01;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_alarm u_tod_alarm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .cal_sec(cal_sec), .cal_min(cal_min),
    .cal_hour(cal_hour), .cal_date(cal_date), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic set_alarm(input logic [7:0] s, m, h, d);
    wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, d);
  endtask

  task automatic fire(input string req, input logic [7:0] s, m, h, d, input logic exp);
    @(negedge clk);
    cal_sec = s; cal_min = m; cal_hour = h; cal_date = d; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check(req, {7'b0, irq}, {7'b0, exp});
    @(negedge clk);
    check({req, " width"}, {7'b0, irq}, 8'h00);
  endtask

  task automatic t_reset;
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd_check("R1 sec", 3'd0, 8'h00);
    rd_check("R1 date", 3'd3, 8'h00);
    rd_check("R1 ctrl", 3'd4, 8'h00);
  endtask

  task automatic t_regs;
    set_alarm(8'hD9, 8'h30, 8'h23, 8'h31);
    rd_check("R2 sec mask kept", 3'd0, 8'hD9);
    rd_check("R2 min", 3'd1, 8'h30);
    rd_check("R2 hour", 3'd2, 8'h23);
    rd_check("R2 date", 3'd3, 8'h31);
    wr(3'd4, 8'hFF);
    rd_check("R2 ctrl", 3'd4, 8'h01);
    wr(3'd6, 8'hAA);
    rd_check("R2 unused", 3'd6, 8'h00);
  endtask

  task automatic t_reject;
    wr(3'd0, 8'h60);
    rd_check("R3 sec 60 dropped", 3'd0, 8'hD9);
    wr(3'd1, 8'h1F);
    rd_check("R3 min 1F accepted", 3'd1, 8'h1F);
    wr(3'd1, 8'h5A);
    rd_check("R3 min 5A dropped", 3'd1, 8'h1F);
    wr(3'd2, 8'h24);
    rd_check("R4 hour 24 dropped", 3'd2, 8'h23);
    wr(3'd2, 8'h8F);
    rd_check("R4 hour 8F accepted", 3'd2, 8'h8F);
    wr(3'd3, 8'hE0);
    rd_check("R5 date zero dropped", 3'd3, 8'h31);
    wr(3'd3, 8'h9F);
    rd_check("R5 date 9F accepted", 3'd3, 8'h9F);
  endtask

  task automatic t_monthly;
    set_alarm(8'h15, 8'h30, 8'h12, 8'h07);
    fire("R6 full match", 8'h15, 8'h30, 8'h12, 8'h07, 1'b1);
    fire("R6 date differs", 8'h15, 8'h30, 8'h12, 8'h08, 1'b0);
    fire("R6 sec differs", 8'h16, 8'h30, 8'h12, 8'h07, 1'b0);
  endtask

  task automatic t_daily;
    set_alarm(8'h15, 8'h30, 8'h12, 8'h87);
    fire("R7 other day", 8'h15, 8'h30, 8'h12, 8'h21, 1'b1);
    fire("R7 hour differs", 8'h15, 8'h30, 8'h13, 8'h21, 1'b0);
  endtask

  task automatic t_hourly;
    set_alarm(8'h15, 8'h30, 8'h92, 8'h87);
    fire("R8 any hour", 8'h15, 8'h30, 8'h05, 8'h02, 1'b1);
    fire("R8 min differs", 8'h15, 8'h31, 8'h05, 8'h02, 1'b0);
  endtask

  task automatic t_minutely;
    set_alarm(8'h15, 8'hB0, 8'h92, 8'h87);
    fire("R9 any minute", 8'h15, 8'h44, 8'h05, 8'h02, 1'b1);
    fire("R9 sec differs", 8'h16, 8'h44, 8'h05, 8'h02, 1'b0);
  endtask

  task automatic t_every;
    set_alarm(8'h95, 8'h30, 8'h12, 8'h07);
    fire("R10 seconds mask only", 8'h01, 8'h02, 8'h03, 8'h04, 1'b1);
    set_alarm(8'h15, 8'hB0, 8'h12, 8'h87);
    fire("R10 mixed pattern", 8'h59, 8'h00, 8'h00, 8'h01, 1'b1);
  endtask

  task automatic t_enable;
    wr(3'd4, 8'h00);
    fire("R11 disabled", 8'h59, 8'h00, 8'h00, 8'h01, 1'b0);
    wr(3'd4, 8'h01);
    @(negedge clk);
    cal_sec = 8'h15; cal_min = 8'h30; cal_hour = 8'h12; cal_date = 8'h07;
    @(negedge clk);
    check("R11 no tick no pulse", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_reject();
    t_monthly();
    t_daily();
    t_hourly();
    t_minutely();
    t_every();
    t_enable();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule